// File: doc/BRIEF.md
# Linked-List Chain Walker for Memory-to-Device Transfers

The walker follows a chain of packets held in word-addressed memory and streams every packet's payload words, in order, to a device write port. Each packet starts with one header word that gives the payload length and the address of the following packet. A walk is armed by a start pulse, which loads the first packet address. After that, the walker advances only while the channel request input stays high.

Three conditions end or suspend a walk. A next pointer with its end bit set completes the walk. A request that has dropped at a packet boundary parks the walker. A spent cycle budget, or an empty packet that points to itself, places the walker in a timed halt. Whenever the walker stops, its resume address output holds the packet it would visit next, so the walk can continue where it left off. The memory read port has a fixed latency of one cycle. The slice budget and the halt length are configuration inputs.

Top module: `chain_dma_walker`

## Requirements
- R1: After reset the walker is idle. busy, memRdReq, devWrValid, doneStrobe and haltActive are low, and resumeAddr is zero.
- R2: A start pulse taken while the walker is idle and chanReq is high loads baseAddr. In the next cycle the walker issues a header read at that address. The header holds the payload word count in bits 31:24 and the next packet address in bits 23:0.
- R3: A packet's payload is read from the header address plus 4 onward, in steps of 4, one read per cycle. Reads begin two cycles after the header read. Each word appears on devWrData with devWrValid high one cycle after its read, in address order.
- R4: A packet with a zero word count whose next pointer differs from its own address sends no beats, and the walk moves on to the next packet.
- R5: A next pointer with bit 23 set ends the walk. doneStrobe pulses high for one cycle, busy is low at that time, and resumeAddr holds the masked next pointer. A new start pulse is then required.
- R6: An empty packet whose masked next pointer equals its own address causes a halt and not an endless loop. resumeAddr stays at that packet and doneStrobe never rises.
- R7: Every memory read costs one budget cycle. After a packet is finished, if sliceBudget or more reads have been made since the walk last left idle, the walker halts. A halt keeps haltActive high for exactly haltLen+1 consecutive cycles, with resumeAddr holding the next packet. The walk then resumes from that packet without a new start pulse.
- R8: chanReq is checked before each header read. If it is low, the walker returns to idle with resumeAddr at the pending packet. It continues from there, without a start pulse, once chanReq is high again.
- R9: A start pulse received while busy is high has no effect on the walk.
- R10: Addresses are cut to ADDR_W bits, with the two low bits forced to zero, before use. This applies to baseAddr, to next pointers and to resumeAddr.
- R11: No memory read is issued while haltActive is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanReq | input | 1 | Channel request; the walk advances only while it is high |
| startKick | input | 1 | Start pulse that arms a walk at baseAddr |
| baseAddr | input | ADDR_W | Byte address of the first packet |
| sliceBudget | input | BUD_W | Read cycles allowed per slice |
| haltLen | input | HALT_W | Halt length minus one, in cycles |
| memRdReq | output | 1 | Memory read strobe |
| memRdAddr | output | ADDR_W | Word-aligned memory read address |
| memRdData | input | 32 | Read data, valid one cycle after memRdReq |
| devWrValid | output | 1 | Payload beat valid |
| devWrData | output | 32 | Payload beat data |
| busy | output | 1 | High while a walk or a halt is in progress |
| haltActive | output | 1 | High during the halt countdown |
| doneStrobe | output | 1 | One-cycle pulse when a walk completes |
| resumeAddr | output | ADDR_W | Current or next packet address |

## Verification
The header read is due in the first cycle after the edge that samples the start pulse. The first payload read follows two cycles later, and each payload beat lands one cycle after its read. doneStrobe rises in the cycle after the last beat. The bench drives inputs 5 ns after a rising edge and samples at that point or at the falling edge. It checks the R2 and R3 latencies cycle by cycle in the directed timing test. The table-driven runs collect beats, halt cycles and done pulses over whole walks and compare them with a chain walk computed from the bench's own memory image. This keeps those runs independent of exact cycle counts, while halt length and reads during a halt are checked cycle by cycle.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;
  localparam int HDR_CNT_W = 8;
  localparam int NEXT_W    = 24;
  localparam int END_BIT   = 23;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DEC, ST_PAY, ST_ADV, ST_HALT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;
    logic clrUsed;
    logic hdrRead;
    logic latchHdr;
    logic payRead;
    logic commitNext;
    logic loadHalt;
    logic decHalt;
  } walkCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic hdrEmpty;
    logic selfLoop;
    logic endMark;
    logic payLast;
    logic budgetHit;
    logic haltZero;
  } walkStat_t;
endpackage

// File: rtl/chain_walk_dp.sv
module chain_walk_dp
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BUD_W  = 16,
  parameter int HALT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [BUD_W-1:0]  sliceBudget,
  input  logic [HALT_W-1:0] haltLen,
  input  logic [31:0]       memRdData,
  output walkStat_t         stat,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              devWrValid,
  output logic [31:0]       devWrData,
  output logic [ADDR_W-1:0] curAddr
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic [ADDR_W-1:0]    payAddr;
  logic [NEXT_W-1:0]    nextRaw;
  logic [HDR_CNT_W-1:0] remaining;
  logic [BUD_W-1:0]     used;
  logic [HALT_W-1:0]    haltCnt;
  logic                 beatValid;

  function automatic logic [ADDR_W-1:0] maskNext(input logic [NEXT_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a[ADDR_W-1:0];
    r[1:0] = 2'b00;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      payAddr   <= '0;
      nextRaw   <= '0;
      remaining <= '0;
      used      <= '0;
      haltCnt   <= '0;
      beatValid <= 1'b0;
    end else begin
      beatValid <= cmd.payRead;
      if (cmd.loadBase)
        curAddr <= {baseAddr[ADDR_W-1:2], 2'b00};
      else if (cmd.commitNext)
        curAddr <= maskNext(nextRaw);
      if (cmd.latchHdr) begin
        nextRaw   <= memRdData[NEXT_W-1:0];
        remaining <= memRdData[31:32-HDR_CNT_W];
        payAddr   <= curAddr + WORD_STEP;
      end else if (cmd.payRead) begin
        payAddr   <= payAddr + WORD_STEP;
        remaining <= remaining - 1'b1;
      end
      if (cmd.clrUsed)
        used <= '0;
      else if ((cmd.hdrRead || cmd.payRead) && (used != '1))
        used <= used + 1'b1;
      if (cmd.loadHalt)
        haltCnt <= haltLen;
      else if (cmd.decHalt)
        haltCnt <= haltCnt - 1'b1;
    end
  end

  always_comb begin
    stat.hdrEmpty  = (memRdData[31:32-HDR_CNT_W] == '0);
    stat.selfLoop  = (maskNext(memRdData[NEXT_W-1:0]) == curAddr);
    stat.endMark   = nextRaw[END_BIT];
    stat.payLast   = (remaining == HDR_CNT_W'(1));
    stat.budgetHit = (used >= sliceBudget);
    stat.haltZero  = (haltCnt == '0);
  end

  assign memRdAddr  = cmd.hdrRead ? curAddr : payAddr;
  assign devWrValid = beatValid;
  assign devWrData  = memRdData;
endmodule

// File: rtl/chain_walk_ctrl.sv
module chain_walk_ctrl
  import chain_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chanReq,
  input  logic      startKick,
  input  walkStat_t stat,
  output walkCmd_t  cmd,
  output logic      busy,
  output logic      haltActive,
  output logic      doneStrobe
);
  walkState_e state, stateNxt;
  logic armed, armedNxt, doneNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    armedNxt = armed;
    doneNxt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startKick) begin
          cmd.loadBase = 1'b1;
          cmd.clrUsed  = 1'b1;
          armedNxt     = 1'b1;
          if (chanReq) stateNxt = ST_HDR;
        end else if (armed && chanReq) begin
          cmd.clrUsed = 1'b1;
          stateNxt    = ST_HDR;
        end
      end
      ST_HDR: begin
        if (!chanReq) stateNxt = ST_IDLE;
        else begin
          cmd.hdrRead = 1'b1;
          stateNxt    = ST_DEC;
        end
      end
      ST_DEC: begin
        cmd.latchHdr = 1'b1;
        if (!stat.hdrEmpty) stateNxt = ST_PAY;
        else if (stat.selfLoop) begin
          cmd.loadHalt = 1'b1;
          stateNxt     = ST_HALT;
        end else stateNxt = ST_ADV;
      end
      ST_PAY: begin
        cmd.payRead = 1'b1;
        if (stat.payLast) stateNxt = ST_ADV;
      end
      ST_ADV: begin
        cmd.commitNext = 1'b1;
        if (stat.endMark) begin
          armedNxt = 1'b0;
          doneNxt  = 1'b1;
          stateNxt = ST_IDLE;
        end else if (stat.budgetHit) begin
          cmd.loadHalt = 1'b1;
          stateNxt     = ST_HALT;
        end else stateNxt = ST_HDR;
      end
      ST_HALT: begin
        if (stat.haltZero) stateNxt = ST_IDLE;
        else cmd.decHalt = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      state      <= stateNxt;
      armed      <= armedNxt;
      doneStrobe <= doneNxt;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign haltActive = (state == ST_HALT);
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int BUD_W  = 16,
  parameter int HALT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanReq,
  input  logic              startKick,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [BUD_W-1:0]  sliceBudget,
  input  logic [HALT_W-1:0] haltLen,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              devWrValid,
  output logic [31:0]       devWrData,
  output logic              busy,
  output logic              haltActive,
  output logic              doneStrobe,
  output logic [ADDR_W-1:0] resumeAddr
);
  walkCmd_t  cmd;
  walkStat_t stat;

  chain_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .startKick(startKick),
    .stat(stat), .cmd(cmd), .busy(busy), .haltActive(haltActive),
    .doneStrobe(doneStrobe)
  );

  chain_walk_dp #(.ADDR_W(ADDR_W), .BUD_W(BUD_W), .HALT_W(HALT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .baseAddr(baseAddr),
    .sliceBudget(sliceBudget), .haltLen(haltLen), .memRdData(memRdData),
    .stat(stat), .memRdAddr(memRdAddr), .devWrValid(devWrValid),
    .devWrData(devWrData), .curAddr(resumeAddr)
  );

  assign memRdReq = cmd.hdrRead | cmd.payRead;
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdReq,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              devWrValid,
  input logic              busy,
  input logic              haltActive,
  input logic              doneStrobe,
  input logic [ADDR_W-1:0] resumeAddr
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdReq);
  assert_beat_after_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    devWrValid |-> $past(memRdReq));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (!busy && !haltActive));
  assert_halt_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (haltActive && $past(haltActive)) |-> $stable(resumeAddr));
  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (memRdAddr[1:0] == 2'b00));
  assert_no_read_in_halt_R11: assert property (@(posedge clk) disable iff (!rstN)
    haltActive |-> !memRdReq);
endmodule

bind chain_dma_walker chain_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
  .devWrValid(devWrValid), .busy(busy), .haltActive(haltActive),
  .doneStrobe(doneStrobe), .resumeAddr(resumeAddr)
);

// File: tb/chain_dma_walker_tb.sv
module chain_dma_walker_tb;
  localparam int ADDR_W = 21;
  localparam int BUD_W  = 16;
  localparam int HALT_W = 16;
  localparam logic [ADDR_W-1:0] AMASK = 21'h1FFFFC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chanReq = 1'b0;
  logic startKick = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [BUD_W-1:0] sliceBudget = 16'd100;
  logic [HALT_W-1:0] haltLen = '0;
  logic memRdReq;
  logic [ADDR_W-1:0] memRdAddr;
  logic [31:0] memRdData = '0;
  logic devWrValid;
  logic [31:0] devWrData;
  logic busy, haltActive, doneStrobe;
  logic [ADDR_W-1:0] resumeAddr;

  always #10 clk = ~clk;

  chain_dma_walker #(.ADDR_W(ADDR_W), .BUD_W(BUD_W), .HALT_W(HALT_W)) u_dut (
    .clk(clk), .rstN(rstN), .chanReq(chanReq), .startKick(startKick),
    .baseAddr(baseAddr), .sliceBudget(sliceBudget), .haltLen(haltLen),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .devWrValid(devWrValid), .devWrData(devWrData), .busy(busy),
    .haltActive(haltActive), .doneStrobe(doneStrobe), .resumeAddr(resumeAddr)
  );

  logic [31:0] mem [0:511];
  always_ff @(posedge clk) if (memRdReq) memRdData <= mem[memRdAddr[10:2]];

  int tests = 0, fails = 0;
  logic collecting = 1'b0;
  int gotN, doneCnt, haltCycles, haltRun, haltRunMax, readsInHalt;
  logic [31:0] gotQ [0:63];
  int expN;
  logic [31:0] expQ [0:63];

  always @(negedge clk) if (collecting) begin
    if (devWrValid && gotN < 64) begin gotQ[gotN] = devWrData; gotN++; end
    if (doneStrobe) doneCnt++;
    if (haltActive) begin
      haltCycles++; haltRun++;
      if (haltRun > haltRunMax) haltRunMax = haltRun;
    end else if (haltRun > 0 && haltRunMax == 0) haltRunMax = haltRun;
    else haltRun = 0;
    if (haltActive && memRdReq) readsInHalt++;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic doReset();
    collecting = 1'b0; chanReq = 1'b0; startKick = 1'b0;
    rstN = 1'b0; repeat (3) tick(); rstN = 1'b1; tick();
  endtask

  task automatic clearMon();
    gotN = 0; doneCnt = 0; haltCycles = 0; haltRun = 0; haltRunMax = 0; readsInHalt = 0;
  endtask

  task automatic pulseStart(input logic [ADDR_W-1:0] a);
    baseAddr = a; startKick = 1'b1; tick(); startKick = 1'b0;
  endtask

  // walk the bench memory image by the header rules
  task automatic buildExpected(input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] a;
    logic [31:0] h;
    expN = 0;
    a = base & AMASK;
    for (int n = 0; n < 16; n++) begin
      h = mem[a[10:2]];
      for (int i = 0; i < int'(h[31:24]); i++) begin
        expQ[expN] = mem[10'((a + ADDR_W'(4 + 4 * i)) >> 2)];
        expN++;
      end
      if (h[31:24] == 0 && (h[ADDR_W-1:0] & AMASK) == a) break;
      if (h[23]) break;
      a = h[ADDR_W-1:0] & AMASK;
    end
  endtask

  task automatic checkBeats(input string tag);
    check(gotN == expN, {tag, " beat count"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      check(gotQ[i] == expQ[i], {tag, " beat data"}, gotQ[i], expQ[i]);
  endtask

  task automatic waitDone(input int limit);
    for (int c = 0; c < limit && doneCnt == 0; c++) tick();
    repeat (3) tick();
  endtask

  typedef struct packed {
    logic [20:0] base;
    logic [15:0] budget;
    logic [15:0] halt;
    logic        done;
    logic        haltSeen;
    logic [20:0] resume;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{21'h100, 16'd100, 16'd3, 1'b1, 1'b0, 21'h000000},   // R2 R3 R4 R5
    '{21'h100, 16'd3,   16'd3, 1'b1, 1'b1, 21'h000000},   // R7
    '{21'h400, 16'd100, 16'd0, 1'b1, 1'b0, 21'h1FFFFC},   // R10
    '{21'h500, 16'd100, 16'd4, 1'b0, 1'b1, 21'h000540}    // R6
  };

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_0000 | i;
    mem[32'h100 >> 2] = {8'd2, 24'h000200};
    mem[32'h104 >> 2] = 32'hA000_0001;
    mem[32'h108 >> 2] = 32'hA000_0002;
    mem[32'h200 >> 2] = {8'd0, 24'h000300};
    mem[32'h300 >> 2] = {8'd3, 24'h800000};
    mem[32'h304 >> 2] = 32'hB000_0001;
    mem[32'h308 >> 2] = 32'hB000_0002;
    mem[32'h30C >> 2] = 32'hB000_0003;
    mem[32'h400 >> 2] = {8'd1, 24'h600480};
    mem[32'h404 >> 2] = 32'hC000_0001;
    mem[32'h480 >> 2] = {8'd1, 24'hFFFFFF};
    mem[32'h484 >> 2] = 32'hC000_0002;
    mem[32'h500 >> 2] = {8'd1, 24'h000540};
    mem[32'h504 >> 2] = 32'hD000_0001;
    mem[32'h540 >> 2] = {8'd0, 24'h000540};

    doReset();
    // R1 reset state
    check(!busy && !memRdReq && !devWrValid, "R1 idle outputs", {busy, memRdReq, devWrValid}, 0);
    check(!doneStrobe && !haltActive, "R1 done/halt", {doneStrobe, haltActive}, 0);
    check(resumeAddr == 0, "R1 resumeAddr", resumeAddr, 0);

    // table-driven whole walks
    for (int v = 0; v < 4; v++) begin
      doReset();
      sliceBudget = VECS[v].budget; haltLen = VECS[v].halt;
      clearMon(); collecting = 1'b1; chanReq = 1'b1;
      pulseStart(VECS[v].base);
      waitDone(150);
      collecting = 1'b0;
      buildExpected(VECS[v].base);
      checkBeats($sformatf("R3 vec%0d", v));
      check((doneCnt == 1) == VECS[v].done, $sformatf("R5/R6 vec%0d done", v), doneCnt, VECS[v].done);
      check((haltCycles > 0) == VECS[v].haltSeen, $sformatf("R7/R6 vec%0d halt", v), haltCycles, VECS[v].haltSeen);
      check(resumeAddr == VECS[v].resume, $sformatf("R5/R6/R10 vec%0d resumeAddr", v), resumeAddr, VECS[v].resume);
      check(readsInHalt == 0, $sformatf("R11 vec%0d reads in halt", v), readsInHalt, 0);
    end

    // R2 R3 cycle timing
    doReset();
    sliceBudget = 16'd100; chanReq = 1'b1;
    pulseStart(21'h100);
    check(memRdReq && memRdAddr == 21'h100, "R2 header read addr", memRdAddr, 21'h100);
    tick();
    check(!memRdReq, "R2 decode cycle no read", memRdReq, 0);
    tick();
    check(memRdReq && memRdAddr == 21'h104, "R3 first payload read", memRdAddr, 21'h104);
    tick();
    check(memRdReq && memRdAddr == 21'h108, "R3 second payload read", memRdAddr, 21'h108);
    check(devWrValid && devWrData == 32'hA000_0001, "R3 first beat", devWrData, 32'hA000_0001);
    tick();
    check(devWrValid && devWrData == 32'hA000_0002, "R3 second beat", devWrData, 32'hA000_0002);

    // R8 request drop and resume
    doReset();
    sliceBudget = 16'd100; clearMon(); collecting = 1'b1; chanReq = 1'b1;
    pulseStart(21'h100);
    tick(); tick();
    chanReq = 1'b0;
    repeat (10) tick();
    check(!busy, "R8 parked idle", busy, 0);
    check(resumeAddr == 21'h200, "R8 resumeAddr", resumeAddr, 21'h200);
    check(gotN == 2, "R8 beats before drop", gotN, 2);
    chanReq = 1'b1;
    waitDone(100);
    collecting = 1'b0;
    check(gotN == 5 && doneCnt == 1, "R8 resume completes", gotN, 5);

    // R9 start while busy ignored
    doReset();
    clearMon(); collecting = 1'b1; chanReq = 1'b1;
    pulseStart(21'h100);
    tick();
    pulseStart(21'h400);
    waitDone(100);
    collecting = 1'b0;
    buildExpected(21'h100);
    checkBeats("R9 late start");

    // R7 halt length, R10 unaligned base
    doReset();
    sliceBudget = 16'd1; haltLen = 16'd5;
    clearMon(); collecting = 1'b1; chanReq = 1'b1;
    pulseStart(21'h103);
    check(memRdAddr == 21'h100, "R10 base aligned", memRdAddr, 21'h100);
    for (int c = 0; c < 12 && !haltActive; c++) tick();
    check(haltActive && resumeAddr == 21'h200, "R7 halt resume addr", resumeAddr, 21'h200);
    haltRun = 0; haltRunMax = 0;
    waitDone(150);
    collecting = 1'b0;
    check(haltRunMax == 6, "R7 halt length", haltRunMax, 6);
    check(readsInHalt == 0, "R11 no reads in halt", readsInHalt, 0);
    check(gotN == 5 && doneCnt == 1, "R7 walk completes after halts", gotN, 5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule